// File: doc/BRIEF.md
# Flash Segment Window Decoder

This block keeps one segment register per flash chip select (five by default) and uses them to route bus addresses. Each register describes a window in 8 MB units. The end unit sits in bits [31:24], the start unit sits in bits [23:16], and bits [15:0] are always zero. The decoded window runs from `start << 23` up to `end << 23`, with the end excluded. A registered decoder returns the chip select that an incoming bus address falls in and the byte offset within that segment. It flags a miss when no segment claims the address. When more than one segment matches, the lowest index wins.

Software changes a segment by writing its register at byte offset 0x30 + 4·cs. A write-check state machine handles each write:

- `ST_IDLE → ST_CHECK` when a write hits a segment offset and carries field values that differ from the current ones.
- `ST_CHECK → ST_COMMIT` when no rule is broken.
- `ST_CHECK → ST_REJECT` otherwise.
- `ST_COMMIT → ST_IDLE` and `ST_REJECT → ST_IDLE` unconditionally.

The register changes on the edge that leaves `ST_COMMIT`. Each of `ST_COMMIT` and `ST_REJECT` raises its own one-cycle result pulse. A start that is not a multiple of the new size is reported on the misalignment output but is still committed.

At reset the registers take their defaults from parameters. In the default setting there is a 256 MB window at 0x20000000. Chip select 0 is 64 MB at 0x20000000, and chip selects 1 to 4 are 32 MB each, packed upward from 0x24000000.

Top module: `seg_window_decoder`

## Requirements
- R1: After reset, the segment registers read 0x48400000, 0x4C480000, 0x504C0000, 0x54500000 and 0x58540000 for chip selects 0 to 4.
- R2: Segment register cs is read and written at byte offset 0x30+4*cs. The end unit is in [31:24] and the start unit in [23:16]. Bits [15:0] read as zero, and the low 16 bits of a write are discarded.
- R3: A write to chip select 0 whose start unit differs from the window base unit (0x40) is rejected and leaves the register unchanged.
- R4: A write is rejected if its end unit is at or below the window base unit (0x40), or if its start unit is above base plus window size (0x60).
- R5: A write is rejected if, for any other chip select, new_start < other_end and new_end > other_start.
- R6: An accepted write whose end exceeds its start, and whose start is not a multiple of (end-start), pulses wr_misalign together with wr_done and is still committed.
- R7: A write whose bits [31:16] equal the current register fields produces no pulse and no busy cycle.
- R8: A qualifying write raises cfg_busy from the next cycle. The cycle after that, exactly one of wr_done or wr_reject pulses. An accepted value is readable one cycle after wr_done. A decode registered on the same edge as the commit still uses the old mapping.
- R9: One cycle after bus_valid, an address inside segment cs gives dec_hit=1, dec_cs=cs and dec_offset=addr-(start<<23). The lowest matching index wins.
- R10: One cycle after bus_valid, an address inside no segment gives dec_miss=1, dec_cs=0 and dec_offset=0.
- R11: The following are dropped: writes while cfg_busy is high, and writes to offsets other than the segment registers. Reads of non-segment offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 8 | Register write byte offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 8 | Register read byte offset |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| cfg_busy | output | 1 | Write check in progress |
| wr_done | output | 1 | One-cycle pulse: write committed |
| wr_reject | output | 1 | One-cycle pulse: write refused |
| wr_misalign | output | 1 | One-cycle pulse with wr_done: misaligned start |
| bus_valid | input | 1 | Address to decode is present |
| bus_addr | input | 32 | Bus byte address |
| dec_hit | output | 1 | Registered: address falls in a segment |
| dec_miss | output | 1 | Registered: address falls in no segment |
| dec_cs | output | 3 | Registered: matched chip select |
| dec_offset | output | 32 | Registered: offset within matched segment |

## Verification
The interaction that needs care is a segment commit and an address decode landing on the same clock edge. The decoder registers its result from the mapping held before that edge. The bench provokes this by holding bus_valid during the commit cycle, with an address that lies just beyond chip select 0's old end but inside its new one. It expects a miss on the first sample and a hit with the new offset on the next. Random write and decode traffic, checked against a bench model of the mapping, adds further overlap between the two paths.

// File: rtl/seg_win_pkg.sv
package seg_win_pkg;

    typedef struct packed {
        logic [7:0] end_u;
        logic [7:0] start_u;
    } seg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_REJECT = 2'd3
    } wr_state_e;

    // Reset layout: chip select 0 first, then equal slices packed upward.
    function automatic seg_t default_seg(input int unsigned cs,
                                         input int unsigned base_u,
                                         input int unsigned first_u,
                                         input int unsigned rest_u);
        int unsigned lo;
        int unsigned hi;
        seg_t        s;
        if (cs == 0) begin
            lo = base_u;
            hi = base_u + first_u;
        end else begin
            lo = base_u + first_u + (cs - 1) * rest_u;
            hi = lo + rest_u;
        end
        s.start_u = lo[7:0];
        s.end_u   = hi[7:0];
        return s;
    endfunction

endpackage

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_win_pkg::*;
#(
    parameter int unsigned NUM_CS     = 5,
    parameter int unsigned CS_W       = 3,
    parameter int unsigned WIN_BASE_U = 8'h40,
    parameter int unsigned WIN_SIZE_U = 32
) (
    input  logic [CS_W-1:0]      cand_cs,
    input  seg_t                 cand,
    input  logic [NUM_CS*16-1:0] segs_flat,
    output logic                 ro_viol,
    output logic                 bound_viol,
    output logic                 overlap_viol,
    output logic                 misalign
);

    localparam logic [8:0] BASE9  = 9'(WIN_BASE_U);
    localparam logic [8:0] LIMIT9 = 9'(WIN_BASE_U + WIN_SIZE_U);

    logic [NUM_CS-1:0] hit_other;
    logic [7:0]        span;

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_ovl
            seg_t other;
            assign other        = segs_flat[i*16 +: 16];
            assign hit_other[i] = (cand_cs != CS_W'(i))
                                && (cand.start_u < other.end_u)
                                && (cand.end_u > other.start_u);
        end
    endgenerate

    always_comb begin
        ro_viol      = (cand_cs == '0) && ({1'b0, cand.start_u} != BASE9);
        bound_viol   = ({1'b0, cand.end_u} <= BASE9) || ({1'b0, cand.start_u} > LIMIT9);
        overlap_viol = |hit_other;
        span         = cand.end_u - cand.start_u;
        misalign     = 1'b0;
        if (cand.end_u > cand.start_u) begin
            misalign = (cand.start_u % span) != 8'd0;
        end
    end

endmodule

// File: rtl/seg_addr_match.sv
module seg_addr_match
    import seg_win_pkg::*;
#(
    parameter int unsigned NUM_CS     = 5,
    parameter int unsigned CS_W       = 3,
    parameter int unsigned BUS_AW     = 32,
    parameter int unsigned UNIT_SHIFT = 23
) (
    input  logic [BUS_AW-1:0]    addr,
    input  logic [NUM_CS*16-1:0] segs_flat,
    output logic                 hit,
    output logic [CS_W-1:0]      hit_cs,
    output logic [BUS_AW-1:0]    hit_offset
);

    localparam int unsigned UW = BUS_AW - UNIT_SHIFT;

    logic [UW-1:0]     unit;
    logic [NUM_CS-1:0] in_seg;
    logic [BUS_AW-1:0] seg_base [NUM_CS];

    assign unit = addr[BUS_AW-1:UNIT_SHIFT];

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
            seg_t s;
            assign s           = segs_flat[i*16 +: 16];
            assign in_seg[i]   = (unit >= UW'(s.start_u)) && (unit < UW'(s.end_u));
            assign seg_base[i] = BUS_AW'(s.start_u) << UNIT_SHIFT;
        end
    endgenerate

    // Scan from the top down so the lowest matching index is the last to write.
    always_comb begin
        hit        = 1'b0;
        hit_cs     = '0;
        hit_offset = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (in_seg[i]) begin
                hit        = 1'b1;
                hit_cs     = CS_W'(i);
                hit_offset = addr - seg_base[i];
            end
        end
    end

endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder
    import seg_win_pkg::*;
#(
    parameter int unsigned NUM_CS      = 5,
    parameter int unsigned BUS_AW      = 32,
    parameter int unsigned UNIT_SHIFT  = 23,
    parameter int unsigned SEG_OFF     = 8'h30,
    parameter int unsigned WIN_BASE_U  = 8'h40,
    parameter int unsigned WIN_SIZE_U  = 32,
    parameter int unsigned DEF_FIRST_U = 8,
    parameter int unsigned DEF_REST_U  = 4,
    localparam int unsigned CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic [7:0]        cfg_rd_addr,
    output logic [31:0]       cfg_rd_data,
    output logic              cfg_busy,
    output logic              wr_done,
    output logic              wr_reject,
    output logic              wr_misalign,
    input  logic              bus_valid,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              dec_hit,
    output logic              dec_miss,
    output logic [CS_W-1:0]   dec_cs,
    output logic [BUS_AW-1:0] dec_offset
);

    localparam logic [7:0] OFF8 = 8'(SEG_OFF);

    // ---------------- segment storage ----------------
    seg_t                 seg_q [NUM_CS];
    logic [NUM_CS*16-1:0] seg_flat;

    wr_state_e       state_q, state_nxt;
    logic [CS_W-1:0] pend_cs;
    seg_t            pend_seg;
    logic            mis_q;

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_seg
            localparam seg_t DEF = default_seg(i, WIN_BASE_U, DEF_FIRST_U, DEF_REST_U);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seg_q[i] <= DEF;
                end else if (state_q == ST_COMMIT && pend_cs == CS_W'(i)) begin
                    seg_q[i] <= pend_seg;
                end
            end
            assign seg_flat[i*16 +: 16] = seg_q[i];
        end
    endgenerate

    // ---------------- register offset decode ----------------
    logic [7:0]      wr_rel, rd_rel;
    logic            wr_sel, rd_sel;
    logic [CS_W-1:0] wr_idx, rd_idx;
    seg_t            wr_cur, rd_cur;
    logic            wr_start;

    always_comb begin
        wr_rel = cfg_wr_addr - OFF8;
        rd_rel = cfg_rd_addr - OFF8;
        wr_sel = (cfg_wr_addr >= OFF8) && (wr_rel[1:0] == 2'b00)
               && (32'(wr_rel[7:2]) < NUM_CS);
        rd_sel = (cfg_rd_addr >= OFF8) && (rd_rel[1:0] == 2'b00)
               && (32'(rd_rel[7:2]) < NUM_CS);
        wr_idx = wr_rel[2 +: CS_W];
        rd_idx = rd_rel[2 +: CS_W];
        wr_cur = '0;
        rd_cur = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (wr_idx == CS_W'(i)) wr_cur = seg_q[i];
            if (rd_idx == CS_W'(i)) rd_cur = seg_q[i];
        end
        cfg_rd_data = rd_sel ? {rd_cur.end_u, rd_cur.start_u, 16'h0000} : 32'h0;
        wr_start    = cfg_wr_en && wr_sel && (cfg_wr_data[31:16] != wr_cur);
    end

    // ---------------- write rule evaluation ----------------
    logic ro_viol, bound_viol, overlap_viol, misalign;

    seg_rule_check #(
        .NUM_CS    (NUM_CS),
        .CS_W      (CS_W),
        .WIN_BASE_U(WIN_BASE_U),
        .WIN_SIZE_U(WIN_SIZE_U)
    ) u_rules (
        .cand_cs     (pend_cs),
        .cand        (pend_seg),
        .segs_flat   (seg_flat),
        .ro_viol     (ro_viol),
        .bound_viol  (bound_viol),
        .overlap_viol(overlap_viol),
        .misalign    (misalign)
    );

    // ---------------- write-check state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_cs  <= '0;
            pend_seg <= '0;
            mis_q    <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (state_q == ST_IDLE && wr_start) begin
                pend_cs  <= wr_idx;
                pend_seg <= cfg_wr_data[31:16];
            end
            if (state_q == ST_CHECK) begin
                mis_q <= misalign;
            end
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_start) state_nxt = ST_CHECK;
            ST_CHECK:  state_nxt = (ro_viol || bound_viol || overlap_viol) ? ST_REJECT : ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            ST_REJECT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cfg_busy    = 1'b1;
        wr_done     = 1'b0;
        wr_reject   = 1'b0;
        wr_misalign = 1'b0;
        unique case (state_q)
            ST_IDLE:   cfg_busy = 1'b0;
            ST_CHECK:  ;
            ST_COMMIT: begin
                wr_done     = 1'b1;
                wr_misalign = mis_q;
            end
            ST_REJECT: wr_reject = 1'b1;
            default:   cfg_busy = 1'b0;
        endcase
    end

    // ---------------- address decode ----------------
    logic              m_hit;
    logic [CS_W-1:0]   m_cs;
    logic [BUS_AW-1:0] m_off;

    seg_addr_match #(
        .NUM_CS    (NUM_CS),
        .CS_W      (CS_W),
        .BUS_AW    (BUS_AW),
        .UNIT_SHIFT(UNIT_SHIFT)
    ) u_match (
        .addr      (bus_addr),
        .segs_flat (seg_flat),
        .hit       (m_hit),
        .hit_cs    (m_cs),
        .hit_offset(m_off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_hit    <= 1'b0;
            dec_miss   <= 1'b0;
            dec_cs     <= '0;
            dec_offset <= '0;
        end else begin
            dec_hit    <= bus_valid && m_hit;
            dec_miss   <= bus_valid && !m_hit;
            dec_cs     <= (bus_valid && m_hit) ? m_cs  : '0;
            dec_offset <= (bus_valid && m_hit) ? m_off : '0;
        end
    end

endmodule

// File: rtl/seg_win_checker.sv
module seg_win_checker #(
    parameter int unsigned NUM_CS     = 5,
    parameter int unsigned CS_W       = 3,
    parameter int unsigned BUS_AW     = 32,
    parameter int unsigned WIN_BASE_U = 8'h40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_busy,
    input logic                 wr_done,
    input logic                 wr_reject,
    input logic                 wr_misalign,
    input logic                 bus_valid,
    input logic                 dec_hit,
    input logic                 dec_miss,
    input logic [CS_W-1:0]      dec_cs,
    input logic [BUS_AW-1:0]    dec_offset,
    input logic [NUM_CS*16-1:0] seg_flat
);

    assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, wr_reject}));

    assert_result_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || wr_reject) |=> !cfg_busy);

    assert_change_only_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seg_flat) |-> $past(wr_done));

    assert_misalign_accepted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_misalign |-> wr_done);

    assert_cs0_start_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_flat[7:0] == 8'(WIN_BASE_U));

    assert_decode_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> (dec_hit != dec_miss));

    assert_miss_zeroed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_miss |-> (dec_offset == '0 && dec_cs == '0));

endmodule

bind seg_window_decoder seg_win_checker #(
    .NUM_CS    (NUM_CS),
    .CS_W      (CS_W),
    .BUS_AW    (BUS_AW),
    .WIN_BASE_U(WIN_BASE_U)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_busy   (cfg_busy),
    .wr_done    (wr_done),
    .wr_reject  (wr_reject),
    .wr_misalign(wr_misalign),
    .bus_valid  (bus_valid),
    .dec_hit    (dec_hit),
    .dec_miss   (dec_miss),
    .dec_cs     (dec_cs),
    .dec_offset (dec_offset),
    .seg_flat   (seg_flat)
);

// File: tb/tb_seg_window_decoder.sv
module tb_seg_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        cfg_busy, wr_done, wr_reject, wr_misalign;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        dec_hit, dec_miss;
    logic [2:0]  dec_cs;
    logic [31:0] dec_offset;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_seg [5];

    always #5 clk = ~clk;

    seg_window_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .cfg_busy(cfg_busy), .wr_done(wr_done), .wr_reject(wr_reject),
        .wr_misalign(wr_misalign),
        .bus_valid(bus_valid), .bus_addr(bus_addr),
        .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_cs(dec_cs), .dec_offset(dec_offset)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Outcome codes: 0 ignored, 1 accepted, 2 accepted+misaligned, 3 rejected.
    function automatic int model_code(input int cs, input logic [31:0] v);
        logic [7:0] s, e;
        bit rej;
        s = v[23:16];
        e = v[31:24];
        if (v[31:16] == m_seg[cs]) return 0;
        rej = (cs == 0 && s != 8'h40) || (e <= 8'h40) || (s > 8'h60);
        for (int i = 0; i < 5; i++)
            if (i != cs && s < m_seg[i][15:8] && e > m_seg[i][7:0]) rej = 1;
        if (rej) return 3;
        if (e > s && (s % (e - s)) != 0) return 2;
        return 1;
    endfunction

    function automatic logic [35:0] model_dec(input logic [31:0] a);
        logic [8:0] u;
        u = a[31:23];
        for (int i = 0; i < 5; i++)
            if (u >= {1'b0, m_seg[i][7:0]} && u < {1'b0, m_seg[i][15:8]})
                return {1'b1, 3'(i), a - ({24'h0, m_seg[i][7:0]} << 23)};
        return '0;
    endfunction

    task automatic rd(input logic [7:0] off, output logic [31:0] d);
        cfg_rd_addr = off;
        #1;
        d = cfg_rd_data;
    endtask

    task automatic wr_check(input int cs, input logic [31:0] v, input int exp, input string tag);
        bit sd, sr, sm, sb;
        int got;
        logic [31:0] rb;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'(8'h30 + 4 * cs); cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        sd = 0; sr = 0; sm = 0; sb = 0;
        for (int k = 0; k < 4; k++) begin
            sb |= cfg_busy; sd |= wr_done; sr |= wr_reject; sm |= wr_misalign;
            @(negedge clk);
        end
        got = sr ? 3 : (sm ? 2 : (sd ? 1 : 0));
        check(got == exp, tag, 32'(got), 32'(exp));
        check(sb == (exp != 0), {tag, " busy"}, 32'(sb), 32'(exp != 0));
        if (exp == 1 || exp == 2) m_seg[cs] = v[31:16];
        rd(8'(8'h30 + 4 * cs), rb);
        check(rb == {m_seg[cs], 16'h0}, {tag, " readback"}, rb, {m_seg[cs], 16'h0});
    endtask

    task automatic dec_check(input logic [31:0] a, input string tag);
        logic [35:0] e;
        e = model_dec(a);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check(dec_hit == e[35] && dec_miss == !e[35], {tag, " hit/miss"},
              {30'h0, dec_hit, dec_miss}, {30'h0, e[35], !e[35]});
        check(dec_cs == e[34:32] && dec_offset == e[31:0], {tag, " cs/offset"},
              dec_offset, e[31:0]);
    endtask

    initial begin
        logic [31:0] rb;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240517);
        m_seg[0] = 16'h4840; m_seg[1] = 16'h4C48; m_seg[2] = 16'h504C;
        m_seg[3] = 16'h5450; m_seg[4] = 16'h5854;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset defaults; R2: low half zero
        for (int i = 0; i < 5; i++) begin
            rd(8'(8'h30 + 4 * i), rb);
            check(rb == {m_seg[i], 16'h0}, "R1 reset segment", rb, {m_seg[i], 16'h0});
        end
        check(!cfg_busy && !dec_hit && !dec_miss, "R1 reset outputs",
              {29'h0, cfg_busy, dec_hit, dec_miss}, 32'h0);
        rd(8'h44, rb);
        check(rb == 32'h0, "R11 unmapped read", rb, 32'h0);

        // R9 / R10: decode on defaults
        dec_check(32'h2000_0010, "R9 cs0");
        check(dec_cs == 3'd0 && dec_offset == 32'h10, "R9 cs0 literal", dec_offset, 32'h10);
        dec_check(32'h2A00_0004, "R9 cs4");
        check(dec_cs == 3'd4 && dec_offset == 32'h4, "R9 cs4 literal", dec_offset, 32'h4);
        dec_check(32'h2C00_0000, "R10 above cs4");
        check(dec_miss == 1'b1, "R10 above literal", {31'h0, dec_miss}, 32'h1);
        dec_check(32'h1FFF_FFFC, "R10 below window");

        wr_check(0, 32'h4841_0000, 3, "R3 cs0 start change");
        wr_check(3, 32'h6461_0000, 3, "R4 start above limit");
        wr_check(3, 32'h4030_0000, 3, "R4 end at base");
        wr_check(2, 32'h504A_0000, 3, "R5 overlap cs1");
        wr_check(2, 32'h504C_0000, 0, "R7 same value");
        wr_check(4, 32'h5855_0000, 2, "R6 misaligned accepted");
        wr_check(0, 32'h4440_0000, 1, "R8 cs0 shrink");
        dec_check(32'h2200_0000, "R10 freed range");
        dec_check(32'h21FF_FFFF, "R9 shrunk cs0");
        wr_check(3, 32'h5450_ABCD, 0, "R2 low bits dropped");

        // R11: non-segment write dropped
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'h44; cfg_wr_data = 32'h1234_5678;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(!cfg_busy, "R11 unmapped write busy", {31'h0, cfg_busy}, 32'h0);
        rd(8'h44, rb);
        check(rb == 32'h0, "R11 unmapped write read", rb, 32'h0);

        // R11: write while busy dropped
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'h30; cfg_wr_data = 32'h4240_0000;
        @(negedge clk);
        cfg_wr_addr = 8'h40; cfg_wr_data = 32'h5854_0000;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        m_seg[0] = 16'h4240;
        rd(8'h30, rb);
        check(rb == 32'h4240_0000, "R11 first write kept", rb, 32'h4240_0000);
        rd(8'h40, rb);
        check(rb == 32'h5855_0000, "R11 busy write dropped", rb, 32'h5855_0000);

        // R8/R9: decode on the commit edge sees the old mapping
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 8'h30; cfg_wr_data = 32'h4440_0000;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        @(negedge clk);
        check(wr_done == 1'b1, "R8 done timing", {31'h0, wr_done}, 32'h1);
        bus_valid = 1'b1; bus_addr = 32'h2100_0000;
        @(negedge clk);
        check(dec_miss == 1'b1, "R8 decode uses old map", {31'h0, dec_miss}, 32'h1);
        @(negedge clk);
        bus_valid = 1'b0;
        check(dec_hit && dec_cs == 3'd0 && dec_offset == 32'h0100_0000,
              "R9 decode uses new map", dec_offset, 32'h0100_0000);
        m_seg[0] = 16'h4440;

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int cs;
            logic [7:0] s, e;
            cs = (n % 3 == 0) ? 0 : int'($urandom % 5);
            s = (cs == 0 && ($urandom % 2) == 0) ? 8'h40 : 8'(8'h3C + $urandom % 8'h28);
            e = 8'(s + $urandom % 7);
            wr_check(cs, {e, s, 16'h0}, model_code(cs, {e, s, 16'h0}), "R5 random write");
            dec_check(32'h1E00_0000 + ($urandom % 32'h1000_0000), "R9 random decode");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule